// File: doc/BRIEF.md
# Page Write Load Controller

This block is the write-control logic of a byte-wide nonvolatile memory. It is written as a synchronous model, and every input is sampled on the rising edge of a system clock. A host writes by driving chip-enable and write-enable low while output-enable is high. The block latches the address when this combined strobe opens and the data when it closes. Each accepted byte goes into a page buffer entry chosen by the low seven address bits, and that entry is marked valid.

After each accepted byte an inactivity timer starts. Another strobe that stays low long enough stops the timer, and the next release restarts it. When the timer runs out, a self-timed programming phase copies the valid buffer entries into the internal array. The page number used is the one carried by the last accepted byte. Entries that were not loaded leave their array locations unchanged. Busy is high for the whole programming phase.

Loading has no back-pressure. A strobe offered while busy is high is dropped, so the host must watch busy before it starts a new page. Reads are refused in the same way while busy is high. The array depth is set by `ADDR_W`. Its default of 11 bits keeps elaboration small, and a full-size instance sets it to 15 (32K bytes). Every duration is a parameter counted in clock cycles.

Top module: `pgwr_ctrl`

## Requirements
- R1: A write strobe counts only in a cycle that samples ce_n=0, we_n=0 and oe_n=1. If oe_n is low, or if ce_n is high, nothing is loaded.
- R2: A strobe whose low time is shorter than GLITCH_CYC samples has no effect. It loads no byte and does not stop a running load timer.
- R3: The address is taken from the first low sample of a strobe. The data is taken from its last low sample.
- R4: Address bits [6:0] select the buffer entry. Bytes may be loaded in any order, and a second load to the same entry replaces the first.
- R5: All loaded entries are programmed into the page given by address bits [ADDR_W-1:7] of the last accepted byte.
- R6: The first high sample after a qualified strobe restarts the load timer. Busy becomes visible after the clock edge that comes BLC_CYC+1 edges after that sample, provided no further strobe qualifies in between.
- R7: While a strobe is held low for GLITCH_CYC samples or longer, the timer is stopped, and programming does not start until after a later release.
- R8: Busy stays high for exactly max(WC_CYC,128) cycles.
- R9: Programming writes only the valid entries. Array locations for entries that were not loaded keep their old contents.
- R10: Strobes during busy are ignored. The buffer is empty after programming, so the next page writes only its own bytes.
- R11: dout_en is asserted one cycle after a sample with ce_n=0, oe_n=0, we_n=1 and busy=0. In that cycle dout equals the array byte at the sampled address. In every other case dout_en is low.
- R12: After reset, busy and dout_en are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; bits [6:0] select the entry, the upper bits select the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data valid, also the output drive enable |
| busy | output | 1 | Programming phase in progress |

## Verification
The hardest states to reach are the ones where the load timer and the strobe qualifier interact. These are a short glitch that lands inside an open load window, a strobe held low far longer than the timeout, and strobes that arrive after programming has begun. The stimulus reaches them through the normal pins. Pulse lengths are chosen relative to GLITCH_CYC, a strobe is held for several times BLC_CYC, and the bench waits just past the timeout before it writes and reads again. A behavioural model that is advanced on every clock predicts busy, dout_en and dout. Every effect is then confirmed by reading the array back once busy has fallen.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_PROG = 2'd2
  } sq_state_t;
endpackage

// File: rtl/pgwr_strobe.sv
// Combines the enables into one write strobe, filters out short pulses,
// latches the address on the first low sample and the data on the last one.
module pgwr_strobe #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int GLITCH_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ld_p,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              hold_p
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] C_FULL = CW'(GLITCH_CYC);
  localparam logic [CW-1:0] C_ONE  = CW'(1);

  logic              low, prev_low, qual;
  logic [CW-1:0]     lcnt, lcnt_nx;
  logic [ADDR_W-1:0] ahold;
  logic [DATA_W-1:0] dhold;

  assign low = ~ce_n & ~we_n & oe_n & ~busy;

  always_comb begin
    if (!prev_low)           lcnt_nx = C_ONE;
    else if (lcnt == C_FULL) lcnt_nx = C_FULL;
    else                     lcnt_nx = lcnt + C_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= 1'b0;
      qual     <= 1'b0;
      lcnt     <= '0;
      ahold    <= '0;
      dhold    <= '0;
      ld_p     <= 1'b0;
      ld_addr  <= '0;
      ld_data  <= '0;
      hold_p   <= 1'b0;
    end else begin
      prev_low <= low;
      ld_p     <= 1'b0;
      hold_p   <= 1'b0;
      if (low) begin
        if (!prev_low) ahold <= addr;
        dhold <= din;
        lcnt  <= lcnt_nx;
        if (lcnt_nx == C_FULL) begin
          qual <= 1'b1;
          if (!qual) hold_p <= 1'b1;
        end
      end else begin
        lcnt <= '0;
        qual <= 1'b0;
        if (prev_low && qual) begin
          ld_p    <= 1'b1;
          ld_addr <= ahold;
          ld_data <= dhold;
        end
      end
    end
  end

  // Tracks that a qualification happened since the last load pulse.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (hold_p) armed <= 1'b1;
    else if (ld_p)   armed <= 1'b0;
  end

  // R2: a load only follows a strobe that was held long enough
  a_r2_load_needs_qual: assert property (@(posedge clk) disable iff (!rst_n)
    ld_p |-> armed);
endmodule

// File: rtl/pgwr_page_buf.sv
// Page buffer: one data byte and one valid flag per entry, plus the page number.
module pgwr_page_buf #(
  parameter int IDX_W  = 7,
  parameter int PG_W   = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [PG_W-1:0]   ld_page,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              busy,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic [PG_W-1:0]   page,
  output logic              any_vld
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [DATA_W-1:0]  dat [ENTRIES];
  logic [ENTRIES-1:0] vld;

  always_ff @(posedge clk) begin
    if (ld && !busy) dat[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      page <= '0;
    end else if (clr) begin
      vld <= '0;
    end else if (ld && !busy) begin
      vld[ld_idx] <= 1'b1;
      page        <= ld_page;
    end
  end

  assign rd_data = dat[rd_idx];
  assign rd_vld  = vld[rd_idx];
  assign any_vld = |vld;

  // R10: loads offered while busy leave the buffer untouched
  a_r10_busy_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && busy && !clr) |=> $stable(vld));
  // R10 / R12: the buffer is empty after programming completes
  a_r10_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld == '0));
endmodule

// File: rtl/pgwr_seq.sv
// Load timer and self-timed programming sequencer.
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int IDX_W    = 7,
  parameter int BLC_CYC  = 40,
  parameter int PROG_CYC = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic             hold,
  output logic             busy,
  output logic             prog_act,
  output logic [IDX_W-1:0] prog_idx,
  output logic             done
);
  localparam int TW = $clog2(BLC_CYC + 1);
  localparam int CW = $clog2(PROG_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(BLC_CYC - 1);
  localparam logic [TW-1:0] T_ONE  = TW'(1);
  localparam logic [CW-1:0] C_LAST = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] C_ONE  = CW'(1);
  localparam logic [CW-1:0] C_PAGE = CW'(1 << IDX_W);

  sq_state_t     state;
  logic [TW-1:0] tmr;
  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      tmr   <= '0;
      run   <= 1'b0;
      cnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (ld) begin
            state <= SQ_LOAD;
            tmr   <= '0;
            run   <= 1'b1;
          end
        end
        SQ_LOAD: begin
          if (ld) begin
            tmr <= '0;
            run <= 1'b1;
          end else if (hold) begin
            run <= 1'b0;
          end else if (run) begin
            if (tmr == T_LAST) begin
              state <= SQ_PROG;
              run   <= 1'b0;
              cnt   <= '0;
            end else begin
              tmr <= tmr + T_ONE;
            end
          end
        end
        SQ_PROG: begin
          if (cnt == C_LAST) state <= SQ_IDLE;
          else               cnt   <= cnt + C_ONE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state == SQ_PROG);
  assign prog_act = busy && (cnt < C_PAGE);
  assign prog_idx = cnt[IDX_W-1:0];
  assign done     = busy && (cnt == C_LAST);

  // R8: the programming phase runs uninterrupted until its last cycle
  a_r8_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_PROG && cnt != C_LAST) |=> (state == SQ_PROG));
  // R7: a stopped timer never starts programming
  a_r7_stopped_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LOAD && !run && !ld) |=> (state == SQ_LOAD));
endmodule

// File: rtl/pgwr_array.sv
// Storage array with one write port and one registered read port.
module pgwr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 7,
  parameter int GLITCH_CYC = 3,
  parameter int BLC_CYC    = 40,
  parameter int WC_CYC     = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int PAGE     = 1 << IDX_W;
  localparam int PG_W     = ADDR_W - IDX_W;
  localparam int PROG_CYC = (WC_CYC > PAGE) ? WC_CYC : PAGE;

  logic              ld_p, hold_p, prog_act, done, rd_vld, any_vld, rd_go;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data, rd_data;
  logic [IDX_W-1:0]  prog_idx;
  logic [PG_W-1:0]   page;

  pgwr_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .busy(busy),
    .addr(addr), .din(din), .ld_p(ld_p), .ld_addr(ld_addr), .ld_data(ld_data),
    .hold_p(hold_p)
  );

  pgwr_page_buf #(.IDX_W(IDX_W), .PG_W(PG_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .ld(ld_p), .ld_idx(ld_addr[IDX_W-1:0]),
    .ld_page(ld_addr[ADDR_W-1:IDX_W]), .ld_data(ld_data), .busy(busy), .clr(done),
    .rd_idx(prog_idx), .rd_data(rd_data), .rd_vld(rd_vld), .page(page),
    .any_vld(any_vld)
  );

  pgwr_seq #(.IDX_W(IDX_W), .BLC_CYC(BLC_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .ld(ld_p), .hold(hold_p), .busy(busy),
    .prog_act(prog_act), .prog_idx(prog_idx), .done(done)
  );

  assign rd_go = ~ce_n & ~oe_n & we_n & ~busy;

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(prog_act & rd_vld), .waddr({page, prog_idx}), .wdata(rd_data),
    .rd(rd_go), .raddr(addr), .rdata(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_en <= 1'b0;
    else        dout_en <= rd_go;
  end

  // R11: no read data is presented in the cycle after a busy cycle
  a_r11_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_en);
  // R9: programming only starts with at least one loaded entry
  a_r9_prog_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(any_vld));
endmodule

// File: tb/pgwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module pgwr_ctrl_tb_top;
  localparam int ADDR_W = 11;
  localparam int G      = 3;
  localparam int BLC    = 40;
  localparam int WC     = 300;
  localparam int PROG   = (WC > 128) ? WC : 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en, busy;

  always #4 clk = ~clk;

  pgwr_ctrl #(.ADDR_W(ADDR_W), .GLITCH_CYC(G), .BLC_CYC(BLC), .WC_CYC(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
  );

  int checks = 0, fails = 0;
  string tag = "R12";

  // behavioural reference model
  logic [7:0] mem [int];
  int  bufd [128];
  bit  bufv [128];
  int  m_page, m_lowcnt, m_ahold, m_dhold, p_addr, p_data;
  bit  m_prevlow, m_qual, p_ld, p_hold, m_busy, exp_en, exp_known;
  int  deadline = -1, prog_end = 0, n = 0;
  logic [7:0] exp_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_prevlow = 0; m_qual = 0; m_lowcnt = 0; p_ld = 0; p_hold = 0;
      deadline = -1; exp_en = 0;
      foreach (bufv[i]) bufv[i] = 0;
    end else begin
      automatic bit busy0 = m_busy;
      automatic bit low;
      if (p_ld && !busy0) begin
        bufd[p_addr % 128] = p_data; bufv[p_addr % 128] = 1;
        m_page = p_addr / 128; deadline = n + BLC;
      end else if (p_hold && !busy0) deadline = -1;
      if (busy0 && n == prog_end) m_busy = 0;
      else if (!busy0 && deadline == n) begin
        m_busy = 1; prog_end = n + PROG; deadline = -1;
        for (int i = 0; i < 128; i++)
          if (bufv[i]) begin mem[m_page * 128 + i] = 8'(bufd[i]); bufv[i] = 0; end
      end
      low = !ce_n && !we_n && oe_n && !busy0;
      p_ld = 0; p_hold = 0;
      if (low) begin
        automatic int cn = m_prevlow ? ((m_lowcnt + 1 > G) ? G : m_lowcnt + 1) : 1;
        if (!m_prevlow) m_ahold = int'(addr);
        m_dhold = int'(din);
        if (cn == G && !m_qual) p_hold = 1;
        if (cn >= G) m_qual = 1;
        m_lowcnt = cn;
      end else begin
        if (m_prevlow && m_qual) begin p_ld = 1; p_addr = m_ahold; p_data = m_dhold; end
        m_lowcnt = 0; m_qual = 0;
      end
      m_prevlow = low;
      exp_en = !ce_n && !oe_n && we_n && !busy0;
      exp_known = exp_en && mem.exists(int'(addr));
      if (exp_known) exp_dout = mem[int'(addr)];
      n++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (busy !== m_busy) begin
      fails++; $display("FAIL %s busy actual=%0b expected=%0b at cycle %0d", tag, busy, m_busy, n);
    end
    checks++;
    if (dout_en !== exp_en) begin
      fails++; $display("FAIL %s dout_en actual=%0b expected=%0b at cycle %0d", tag, dout_en, exp_en, n);
    end
    if (exp_en && exp_known) begin
      checks++;
      if (dout !== exp_dout) begin
        fails++; $display("FAIL %s dout actual=%02h expected=%02h at cycle %0d", tag, dout, exp_dout, n);
      end
    end
  end

  task automatic wr(input int a, input int d, input int lowc = 4, input int a2 = -1,
                    input bit oe_v = 1'b1, input bit ce_v = 1'b0);
    @(negedge clk);
    addr = ADDR_W'(a); din = 8'(d); ce_n = ce_v; we_n = 1'b0; oe_n = oe_v;
    for (int i = 0; i < lowc; i++) begin
      @(negedge clk);
      if (i == 0 && a2 >= 0) addr = ADDR_W'(a2);
      if (i == lowc - 2) din = 8'(d);
    end
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    addr = ADDR_W'(a); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic settle();
    repeat (BLC + PROG + 20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R12"; checks++;
    if (busy !== 1'b0 || dout_en !== 1'b0) begin
      fails++; $display("FAIL R12 reset busy=%0b dout_en=%0b expected 0 0", busy, dout_en);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R4";   // out-of-order loads, then one entry rewritten
    wr(2*128 + 9, 8'h19); wr(2*128 + 3, 8'h13); wr(2*128 + 7, 8'h17); wr(2*128 + 9, 8'h99);
    tag = "R6"; settle();
    tag = "R4"; rd(2*128 + 3); rd(2*128 + 7); rd(2*128 + 9);

    tag = "R9";   // partial page keeps earlier bytes
    wr(2*128 + 5, 8'h25); settle();
    rd(2*128 + 3); rd(2*128 + 5); rd(2*128 + 7);

    tag = "R2";   // short pulse alone, then a short pulse inside a load window
    wr(2*128 + 3, 8'hEE, G - 1); settle(); rd(2*128 + 3);
    wr(2*128 + 1, 8'h21);
    repeat (10) @(negedge clk);
    wr(2*128 + 7, 8'hEF, G - 1); settle(); rd(2*128 + 1); rd(2*128 + 7);

    tag = "R1";   // output-enable low, then chip-enable high
    wr(2*128 + 5, 8'hA1, 4, -1, 1'b0); wr(2*128 + 5, 8'hA2, 4, -1, 1'b1, 1'b1);
    settle(); rd(2*128 + 5);

    tag = "R3";   // address moves after the first low sample
    wr(3*128 + 2, 8'h32, 5, 3*128 + 4); settle(); rd(3*128 + 2); rd(3*128 + 4);

    tag = "R5";   // page taken from the last byte
    wr(5*128 + 10, 8'h5A); wr(6*128 + 11, 8'h6B); settle();
    rd(6*128 + 10); rd(6*128 + 11);

    tag = "R7";   // strobe held well past the timeout
    wr(7*128 + 1, 8'h71);
    wr(7*128 + 2, 8'h72, 3 * BLC);
    settle(); rd(7*128 + 1); rd(7*128 + 2);

    tag = "R10";  // strobes and reads during busy, then a fresh page
    wr(8*128 + 1, 8'h81);
    repeat (BLC + 8) @(negedge clk);
    wr(8*128 + 2, 8'h82); rd(8*128 + 1);
    tag = "R8"; settle();
    tag = "R10"; rd(8*128 + 1); rd(8*128 + 2);
    wr(8*128 + 3, 8'h83); settle(); rd(8*128 + 1); rd(8*128 + 3);

    tag = "R11";  // reads across pages, and no read when write-enable is low
    rd(2*128 + 9); rd(6*128 + 10);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = ADDR_W'(2*128 + 9);
    repeat (2) @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL %s watchdog expired actual=running expected=finished", tag);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule